// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Synthesizer

This block turns a serial transmit bit stream into a sampled sine carrier for an external DAC. A phase accumulator advances by a step word every clock, and the upper phase bits address a full-wave sine table. The step word selects one of two tones placed symmetrically around a carrier. The caller chooses one of eight carriers, one of four bit rates and one of two deviation factors. The carrier, bit rate and deviation may change while transmitting, and the phase carries on without a jump.

A new data value does not switch the tone at once. It waits in a pending register until the accumulator next crosses 0 or 180 degrees, so the waveform changes frequency at a zero crossing of the sine. While transmit is off, the output sits at zero and the phase returns to 0.

Top module: `fsk_tone_gen`

## Requirements
- R1: After a synchronous reset, `sample` is 0, the phase is 0, and both the active and the pending symbol are 0.
- R2: On every clock edge where `tx_en` is low, `sample` becomes 0, the phase returns to 0, and the active symbol takes the pending value. The next enabled cycle therefore starts again from phase 0.
- R3: On an enabled edge, `sample` becomes trunc(A·sin(2π·k/2^SIN_AW)), where A = 2^(SMP_W-1)-1 and k is the top SIN_AW bits of the phase as it stood before that edge.
- R4: On each enabled edge, the ACC_W-bit phase advances by the current step word modulo 2^ACC_W.
- R5: The carrier frequency is CAR_BASE_HZ + `car_sel`·CAR_STEP_HZ. A change of `car_sel` alters the step from the next edge onward and does not reset the phase.
- R6: The bit rate is BAUD_BASE·2^`baud_sel`, which with the defaults gives 600, 1200, 2400 or 4800 bit/s.
- R7: The deviation is F·rate, with F = 1/2 when `dev_sel`=0 and F = 1 when `dev_sel`=1. Symbol 0 uses the step INC(carrier)+INC(deviation/2), and symbol 1 uses INC(carrier)−INC(deviation/2). Here INC(f) = floor((f·2^ACC_W + CLK_HZ/2)/CLK_HZ).
- R8: `tx_bit` is captured into the pending register on every edge. The active symbol takes the pending value only on an enabled edge where the phase MSB toggles, meaning the phase crosses 0 or 180 degrees. A pending value that reverts before such an edge has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low holds the output at zero |
| tx_bit | input | 1 | Data bit to send |
| car_sel | input | CAR_W | Carrier choice, 0 to 7 |
| dev_sel | input | 1 | Deviation factor: 0 gives half the bit rate, 1 gives the full bit rate |
| baud_sel | input | BAUD_W | Bit rate choice, 0 to 3 |
| sample | output | SMP_W | Signed sine sample for the DAC |

## Verification
A sample produced at a rising edge reflects the phase held before that edge, so it appears one edge after the step that produced that phase. A `tx_bit` value needs one edge to reach the pending register. It can become active no earlier than the crossing edge after that, and the changed step then shows in `sample` one edge later again. The bench keeps its own arithmetic model of the phase, the pending symbol and the active symbol, and advances that model exactly once per rising edge. It drives inputs and compares `sample` on the falling edge, so every expected value lines up with the edge count above. The stimulus sweeps every carrier, rate and deviation without a break in phase. It also includes directed one-cycle glitches on `tx_bit` and mid-stream drops of `tx_en`.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  // Rounded phase step for a tone of f_hz at clock clk_hz with acc_w accumulator bits
  function automatic longint freq_to_inc(longint f_hz, longint clk_hz, int acc_w);
    return (f_hz * (longint'(1) << acc_w) + clk_hz / 2) / clk_hz;
  endfunction
endpackage

// File: rtl/fsk_step_table.sv
module fsk_step_table #(
  parameter int CLK_HZ      = 8192000,
  parameter int ACC_W       = 24,
  parameter int CAR_W       = 3,
  parameter int BAUD_W      = 2,
  parameter int CAR_BASE_HZ = 60000,
  parameter int CAR_STEP_HZ = 10000,
  parameter int BAUD_BASE   = 600
) (
  input  logic [CAR_W-1:0]  car_sel,
  input  logic              dev_sel,
  input  logic [BAUD_W-1:0] baud_sel,
  input  logic              sym,
  output logic [ACC_W-1:0]  step
);
  localparam int N_CAR = 1 << CAR_W;
  localparam int N_HD  = 2 << BAUD_W;

  logic [ACC_W-1:0] center_tab [N_CAR];
  logic [ACC_W-1:0] half_tab   [N_HD];

  for (genvar c = 0; c < N_CAR; c++) begin : g_center
    assign center_tab[c] = ACC_W'(fsk_pkg::freq_to_inc(
        longint'(CAR_BASE_HZ) + longint'(c) * longint'(CAR_STEP_HZ),
        longint'(CLK_HZ), ACC_W));
  end

  // index {dev, rate}: dev 0 -> rate/4, dev 1 -> rate/2
  for (genvar h = 0; h < N_HD; h++) begin : g_half
    localparam longint RATE = longint'(BAUD_BASE) << (h % (1 << BAUD_W));
    localparam longint HALF = (h >= (1 << BAUD_W)) ? RATE / 2 : RATE / 4;
    assign half_tab[h] = ACC_W'(fsk_pkg::freq_to_inc(HALF, longint'(CLK_HZ), ACC_W));
  end

  logic [ACC_W-1:0] ctr_w, half_w;
  assign ctr_w  = center_tab[car_sel];
  assign half_w = half_tab[{dev_sel, baud_sel}];
  assign step   = sym ? (ctr_w - half_w) : (ctr_w + half_w);
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int ACC_W  = 24,
  parameter int SIN_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_in,
  input  logic [ACC_W-1:0]  step,
  output logic              sym,
  output logic [SIN_AW-1:0] phase_top
);
  logic [ACC_W-1:0] phase_q, phase_nx;
  logic             pend_q, sym_q, cross_w;

  assign phase_nx = phase_q + step;
  // MSB toggles exactly when the phase passes 0 or 180 degrees
  assign cross_w  = phase_nx[ACC_W-1] ^ phase_q[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      pend_q  <= 1'b0;
      sym_q   <= 1'b0;
    end else begin
      pend_q <= bit_in;
      if (!en) begin
        phase_q <= '0;
        sym_q   <= pend_q;
      end else begin
        phase_q <= phase_nx;
        if (cross_w) sym_q <= pend_q;
      end
    end
  end

  assign sym       = sym_q;
  assign phase_top = phase_q[ACC_W-1 -: SIN_AW];
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
  parameter int SIN_AW = 8,
  parameter int SMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [SIN_AW-1:0]       addr,
  output logic signed [SMP_W-1:0] dout
);
  localparam int  DEPTH  = 1 << SIN_AW;
  localparam real AMP    = real'((1 << (SMP_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [SMP_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = SMP_W'($rtoi(AMP * $sin(TWO_PI * real'(i) / real'(DEPTH))));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) dout <= '0;
    else            dout <= rom[addr];
  end
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int CLK_HZ      = 8192000,
  parameter int ACC_W       = 24,
  parameter int SIN_AW      = 8,
  parameter int SMP_W       = 12,
  parameter int CAR_W       = 3,
  parameter int BAUD_W      = 2,
  parameter int CAR_BASE_HZ = 60000,
  parameter int CAR_STEP_HZ = 10000,
  parameter int BAUD_BASE   = 600
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_en,
  input  logic                    tx_bit,
  input  logic [CAR_W-1:0]        car_sel,
  input  logic                    dev_sel,
  input  logic [BAUD_W-1:0]       baud_sel,
  output logic signed [SMP_W-1:0] sample
);
  logic [ACC_W-1:0]  step_w;
  logic              sym_w;
  logic [SIN_AW-1:0] phase_top_w;

  fsk_step_table #(
    .CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .CAR_W(CAR_W), .BAUD_W(BAUD_W),
    .CAR_BASE_HZ(CAR_BASE_HZ), .CAR_STEP_HZ(CAR_STEP_HZ), .BAUD_BASE(BAUD_BASE)
  ) step_i (
    .car_sel(car_sel), .dev_sel(dev_sel), .baud_sel(baud_sel),
    .sym(sym_w), .step(step_w)
  );

  fsk_phase_acc #(.ACC_W(ACC_W), .SIN_AW(SIN_AW)) acc_i (
    .clk(clk), .rst(rst), .en(tx_en), .bit_in(tx_bit), .step(step_w),
    .sym(sym_w), .phase_top(phase_top_w)
  );

  fsk_sine_rom #(.SIN_AW(SIN_AW), .SMP_W(SMP_W)) rom_i (
    .clk(clk), .rst(rst), .en(tx_en), .addr(phase_top_w), .dout(sample)
  );
endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
  parameter int SIN_AW = 8,
  parameter int SMP_W  = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tx_en,
  input logic signed [SMP_W-1:0] sample,
  input logic                    sym,
  input logic [SIN_AW-1:0]       phase_top
);
  // R2: idle edge forces a zero sample
  a_r2_idle_sample: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (sample == '0));

  // R2: idle edge returns the phase to zero
  a_r2_idle_phase: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (phase_top == '0));

  // R8: while enabled, the symbol changes only together with a half-cycle crossing
  a_r8_switch_at_cross: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_en) && !$past(rst) && (sym != $past(sym)))
      |-> (phase_top[SIN_AW-1] != $past(phase_top[SIN_AW-1])));

  // R3: the table is symmetric, so the most negative code never appears
  a_r3_sample_bound: assert property (@(posedge clk) disable iff (rst)
    sample != {1'b1, {(SMP_W-1){1'b0}}});
endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(.SIN_AW(SIN_AW), .SMP_W(SMP_W)) chk_i (
  .clk(clk), .rst(rst), .tx_en(tx_en), .sample(sample),
  .sym(sym_w), .phase_top(phase_top_w)
);

// File: tb/fsk_tone_gen_tb.sv
module fsk_tone_gen_tb_top;
  localparam int     CLK_PERIOD = 10;
  localparam longint CLK_HZ = 8192000;
  localparam int     ACC_W = 24, SIN_AW = 8, SMP_W = 12;
  localparam longint MASK = (longint'(1) << ACC_W) - 1;

  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b0, tx_bit = 1'b0, dev_sel = 1'b0;
  logic [2:0] car_sel = '0;
  logic [1:0] baud_sel = '0;
  logic signed [SMP_W-1:0] sample;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  longint m_ph;
  bit     m_sym, m_pend;
  int     m_smp;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_tone_gen dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_bit(tx_bit),
    .car_sel(car_sel), .dev_sel(dev_sel), .baud_sel(baud_sel), .sample(sample)
  );

  function automatic longint inc_of(longint f);
    return (f * (longint'(1) << ACC_W) + CLK_HZ / 2) / CLK_HZ;
  endfunction

  function automatic int sin_of(longint k);
    return $rtoi(2047.0 * $sin(6.283185307179586 * real'(k) / 256.0));
  endfunction

  function automatic longint step_of(int car, bit dev, int baud, bit s);
    longint rate = longint'(600) << baud;
    longint half = dev ? rate / 2 : rate / 4;
    longint ci = inc_of(60000 + car * 10000);
    longint hi = inc_of(half);
    return s ? ci - hi : ci + hi;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    longint st, nx;
    bit cr;
    if (rst) begin
      m_ph = 0; m_sym = 0; m_pend = 0; m_smp = 0;
      return;
    end
    m_smp = tx_en ? sin_of(m_ph >> (ACC_W - SIN_AW)) : 0;
    st = step_of(int'(car_sel), dev_sel, int'(baud_sel), m_sym);
    if (!tx_en) begin
      m_ph = 0; m_sym = m_pend;
    end else begin
      nx = (m_ph + st) & MASK;
      cr = ((m_ph >> (ACC_W-1)) & 1) != ((nx >> (ACC_W-1)) & 1);
      if (cr) m_sym = m_pend;
      m_ph = nx;
    end
    m_pend = tx_bit;
  endtask

  // one rising edge, then model update and compare at the falling edge
  task automatic tick(string req);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    model_step();
    check(int'(sample) == m_smp, req, int'(sample), m_smp);
  endtask

  initial begin
    m_ph = 0; m_sym = 0; m_pend = 0; m_smp = 0;
    // R1: reset state
    for (int i = 0; i < 3; i++) tick("R1");
    rst = 1'b0;
    // R2: idle with toggling data
    for (int i = 0; i < 6; i++) begin tx_bit = i[0]; tick("R2"); end
    // R3 R4 R7 R8: bit stream at 4800 bit/s, carrier 0, full deviation
    tx_en = 1'b1; baud_sel = 2'd3; dev_sel = 1'b1;
    for (int b = 0; b < 5; b++) begin
      tx_bit = (b == 1 || b == 2 || b == 4);
      for (int i = 0; i < 1707; i++) tick("R8");
    end
    // R8: single-cycle glitches that revert before a crossing
    for (int g = 0; g < 40; g++) begin
      tx_bit = ~tx_bit; tick("R8");
      tx_bit = ~tx_bit;
      for (int i = 0; i < 23 + g; i++) tick("R8");
    end
    // R5 R6 R7: sweep every setting without restarting the phase
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 4; r++) begin
          car_sel = 3'(c); dev_sel = d[0]; baud_sel = 2'(r);
          for (int i = 0; i < 300; i++) begin
            if (i % 37 == 0) tx_bit = ~tx_bit;
            tick((i < 2) ? "R5" : (d == 1 ? "R7" : "R6"));
          end
        end
    // R2: drop enable mid-stream, then restart from phase 0
    for (int k = 0; k < 4; k++) begin
      tx_en = 1'b0;
      for (int i = 0; i < 3 + k; i++) begin tx_bit = i[0]; tick("R2"); end
      tx_en = 1'b1;
      for (int i = 0; i < 200; i++) tick("R4");
    end
    // R1: reset during transmission
    rst = 1'b1; tick("R1"); tick("R1");
    rst = 1'b0; tx_en = 1'b0; tick("R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule